// File: doc/BRIEF.md
# Debug Control-Register Read Responder

This block serves one command of a 16-bit word-oriented debug channel: reading a processor control register. A word shifter outside the block delivers each incoming 16-bit word together with a one-cycle strobe. The same transfer carries out the 17-bit response word that the block presents at that moment. Bit 16 of a response is the status flag. When it is clear, bits 15:0 carry data. When it is set, the word is a status code.

After the command word, the host sends the 32-bit register selector as an upper half-word and then a lower half-word. The block then raises a request toward the register file and holds the selector steady until acknowledge, error or timeout. While the fetch is pending, every transfer returns "not ready". A good fetch is returned as two data words, upper half first. Bits that the register file marks as unimplemented are cleared. A failed or timed-out fetch returns a single bus-error word. The transfer that carries out the final response word also delivers the host's next word, and the block treats that word as a possible new command.

States are IDLE, OPND_HI, OPND_LO, FETCH, RES_HI, RES_LO and RES_ERR. The transitions are:
- IDLE to OPND_HI on the command word.
- OPND_HI to OPND_LO on any strobe.
- OPND_LO to FETCH on any strobe.
- FETCH to RES_HI on a good acknowledge.
- FETCH to RES_ERR on an erroring acknowledge or on timeout.
- RES_HI to RES_LO on a strobe.
- RES_LO or RES_ERR on a strobe: to OPND_HI if the word is the command, otherwise to IDLE.

Top module: `dbg_rcr_responder`

## Requirements
- R1: After reset the response word is the not-ready code 17'h10000 and `reg_req` is low.
- R2: In IDLE, a strobed word other than CMD_CODE (default 16'h2980) is ignored: the response stays 17'h10000 and no fetch starts, even when further words follow.
- R3: After the command, the first strobed word becomes selector bits 31:16 and the second becomes bits 15:0. `reg_req` rises in the cycle after the second word with `reg_sel` equal to that selector.
- R4: From the command word until the result is ready, every transfer returns 17'h10000. Words strobed during FETCH are discarded.
- R5: A good fetch returns {1'b0, data[31:16]} on the next transfer and then {1'b0, data[15:0]}.
- R6: Result bits where `reg_impl` is 0 are returned as 0.
- R7: An acknowledge with `reg_err` high returns the single word 17'h10001 in place of the result.
- R8: With no acknowledge within TIMEOUT cycles of FETCH, `reg_req` drops and 17'h10001 is returned. An acknowledge in FETCH cycle TIMEOUT-1 (counting from 0) is still accepted.
- R9: The word strobed during the transfer that carries the last result word or the error word is taken as the next command. If it is not the command, the block goes to IDLE.
- R10: `reg_req` stays high with `reg_sel` unchanged until acknowledge or timeout. `reg_ack`/`reg_err` outside FETCH have no effect.
- R11: A data word always has bit 16 clear, even when its data is all ones. A status word has bits 15:1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | One-cycle strobe: a channel transfer completes |
| rx_word | input | 16 | Word received in that transfer |
| tx_word | output | 17 | Response carried by the current transfer (bit 16 = status flag) |
| reg_req | output | 1 | Register fetch request |
| reg_sel | output | 32 | Register selector for the fetch |
| reg_ack | input | 1 | Fetch complete |
| reg_err | input | 1 | Fetch failed; valid with `reg_ack` |
| reg_rdata | input | 32 | Fetched register value; valid with `reg_ack` |
| reg_impl | input | 32 | Implemented-bit mask of the fetched register; valid with `reg_ack` |

## Verification
The assertions assume that `reg_ack` is a single-cycle pulse, and that `reg_err`, `reg_rdata` and `reg_impl` are meaningful only in the cycle `reg_ack` is high. They also assume `rx_stb` marks one transfer per cycle at most. The bench's register-file model raises acknowledge for exactly one cycle, at a chosen FETCH cycle index, and its data are valid only then. Stray acknowledge pulses are sent only while no fetch is requested, which checks that the block ignores them. The bench sweeps every acknowledge delay from 0 through TIMEOUT (a timeout) over several data and mask patterns, with errors and chained commands mixed in.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int WORD_W = 16;
    localparam int RESP_W = WORD_W + 1;
    localparam logic [RESP_W-1:0] RSP_NOT_READY = 17'h10000;
    localparam logic [RESP_W-1:0] RSP_BUS_ERROR = 17'h10001;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPND_HI,
        S_OPND_LO,
        S_FETCH,
        S_RES_HI,
        S_RES_LO,
        S_RES_ERR
    } rcr_state_e;
endpackage

// File: rtl/rcr_opnd_capture.sv
module rcr_opnd_capture
    import rcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [WORD_W-1:0] word,
    output logic [2*WORD_W-1:0] sel
);
    logic [WORD_W-1:0] half_q [2];
    logic [1:0]        ld;

    assign ld = {load_hi, load_lo};

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                half_q[h] <= '0;
            else if (ld[h])
                half_q[h] <= word;
        end
    end

    assign sel = {half_q[1], half_q[0]};
endmodule

// File: rtl/rcr_timer.sv
module rcr_timer #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LIMIT);
endmodule

// File: rtl/rcr_fsm.sv
module rcr_fsm
    import rcr_pkg::*;
#(
    parameter logic [15:0] CMD_CODE = 16'h2980
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_stb,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              reg_ack,
    input  logic              reg_err,
    input  logic [31:0]       reg_rdata,
    input  logic [31:0]       reg_impl,
    input  logic              expire,
    output logic              load_hi,
    output logic              load_lo,
    output logic              fetch_run,
    output logic              reg_req,
    output logic [RESP_W-1:0] tx_word
);
    rcr_state_e state_q, state_d;
    logic [31:0] res_q;
    logic        is_cmd;

    assign is_cmd = (rx_word == CMD_CODE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (rx_stb && is_cmd) state_d = S_OPND_HI;
            S_OPND_HI: if (rx_stb) state_d = S_OPND_LO;
            S_OPND_LO: if (rx_stb) state_d = S_FETCH;
            S_FETCH: begin
                if (reg_ack)
                    state_d = reg_err ? S_RES_ERR : S_RES_HI;
                else if (expire)
                    state_d = S_RES_ERR;
            end
            S_RES_HI:  if (rx_stb) state_d = S_RES_LO;
            S_RES_LO, S_RES_ERR: begin
                if (rx_stb)
                    state_d = is_cmd ? S_OPND_HI : S_IDLE;
            end
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (state_q == S_FETCH && reg_ack && !reg_err)
            res_q <= reg_rdata & reg_impl;
    end

    always_comb begin
        load_hi   = 1'b0;
        load_lo   = 1'b0;
        fetch_run = 1'b0;
        tx_word   = RSP_NOT_READY;
        unique case (state_q)
            S_IDLE:    ;
            S_OPND_HI: load_hi = rx_stb;
            S_OPND_LO: load_lo = rx_stb;
            S_FETCH:   fetch_run = 1'b1;
            S_RES_HI:  tx_word = {1'b0, res_q[31:16]};
            S_RES_LO:  tx_word = {1'b0, res_q[15:0]};
            S_RES_ERR: tx_word = RSP_BUS_ERROR;
            default:   ;
        endcase
    end

    assign reg_req = fetch_run;

    AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word[16] |-> (tx_word[15:1] == '0)); // R11
    AST_REQ_AFTER_OPND: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lo) |=> reg_req); // R3
    AST_ERR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ack && reg_err) |=> (tx_word == RSP_BUS_ERROR)); // R7
    AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !reg_ack) |=> (tx_word == RSP_BUS_ERROR && !reg_req)); // R8
    AST_ACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ack && !reg_err) |=>
        (tx_word == {1'b0, $past(reg_rdata[31:16] & reg_impl[31:16])})); // R6
endmodule

// File: rtl/dbg_rcr_responder.sv
module dbg_rcr_responder
    import rcr_pkg::*;
#(
    parameter logic [15:0] CMD_CODE = 16'h2980,
    parameter int          TIMEOUT  = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_stb,
    input  logic [15:0] rx_word,
    output logic [16:0] tx_word,
    output logic        reg_req,
    output logic [31:0] reg_sel,
    input  logic        reg_ack,
    input  logic        reg_err,
    input  logic [31:0] reg_rdata,
    input  logic [31:0] reg_impl
);
    logic load_hi, load_lo, fetch_run, expire;

    rcr_opnd_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (load_hi),
        .load_lo (load_lo),
        .word    (rx_word),
        .sel     (reg_sel)
    );

    rcr_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (fetch_run),
        .expire (expire)
    );

    rcr_fsm #(.CMD_CODE(CMD_CODE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_stb    (rx_stb),
        .rx_word   (rx_word),
        .reg_ack   (reg_ack),
        .reg_err   (reg_err),
        .reg_rdata (reg_rdata),
        .reg_impl  (reg_impl),
        .expire    (expire),
        .load_hi   (load_hi),
        .load_lo   (load_lo),
        .fetch_run (fetch_run),
        .reg_req   (reg_req),
        .tx_word   (tx_word)
    );

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && $past(reg_req)) |-> $stable(reg_sel)); // R10
endmodule

// File: tb/dbg_rcr_responder_bench.sv
`timescale 1ns/1ps
module dbg_rcr_responder_bench;
    localparam logic [15:0] CMD = 16'h2980;
    localparam int          TO  = 16;
    localparam logic [16:0] NR  = 17'h10000;
    localparam logic [16:0] BE  = 17'h10001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_stb = 1'b0;
    logic [15:0] rx_word = '0;
    logic [16:0] tx_word;
    logic        reg_req;
    logic [31:0] reg_sel;
    logic        reg_ack = 1'b0;
    logic        reg_err = 1'b0;
    logic [31:0] reg_rdata = '0;
    logic [31:0] reg_impl = '0;

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    int          rsp_delay = 0;
    int          rsp_cnt = 0;
    bit          rsp_err = 0;
    logic [31:0] rsp_data = '0;
    logic [31:0] rsp_impl = '0;
    logic [31:0] seen_sel = '0;
    bit          stray = 0;

    always #4 clk = ~clk;

    dbg_rcr_responder #(.CMD_CODE(CMD), .TIMEOUT(TO)) u_dbg_rcr_responder (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_word(rx_word),
        .tx_word(tx_word), .reg_req(reg_req), .reg_sel(reg_sel),
        .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
        .reg_impl(reg_impl)
    );

    // register-file model: one-cycle acknowledge at FETCH cycle rsp_delay
    initial begin
        forever begin
            @(negedge clk);
            if (reg_req) begin
                if (rsp_cnt == 0) seen_sel = reg_sel;
                reg_ack   = (rsp_cnt == rsp_delay);
                reg_err   = rsp_err && (rsp_cnt == rsp_delay);
                reg_rdata = (rsp_cnt == rsp_delay) ? rsp_data : 32'hDEAD_BEEF;
                reg_impl  = (rsp_cnt == rsp_delay) ? rsp_impl : 32'h0;
                rsp_cnt++;
            end else begin
                rsp_cnt   = 0;
                reg_ack   = stray;
                reg_err   = stray;
                reg_rdata = {32{stray}};
                reg_impl  = {32{stray}};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] w, output logic [16:0] r);
        r = tx_word;
        rx_stb = 1'b1;
        rx_word = w;
        @(negedge clk);
        rx_stb = 1'b0;
        rx_word = '0;
    endtask

    task automatic rd(input logic [31:0] sel, input logic [31:0] data, input logic [31:0] impl,
                      input int d, input bit err, input bit chained, input bit chain_out);
        logic [16:0] r;
        logic [31:0] exp;
        logic [15:0] pw;
        int          polls;
        bit          fail_path;
        exp = data & impl;
        pw = chain_out ? CMD : 16'h0000;
        fail_path = err || (d >= TO);
        rsp_delay = d; rsp_err = err; rsp_data = data; rsp_impl = impl;
        if (!chained) begin
            xfer(CMD, r);
            chk(r == NR, "R4 cmd", {16'h0, r}, {16'h0, NR});
        end else begin
            chk(reg_req == 1'b0, "R9 chained cmd taken", {32'h0, reg_req}, 33'h0);
        end
        xfer(sel[31:16], r);
        chk(r == NR, "R4 opnd hi", {16'h0, r}, {16'h0, NR});
        xfer(sel[15:0], r);
        chk(r == NR, "R4 opnd lo", {16'h0, r}, {16'h0, NR});
        chk(reg_req == 1'b1, "R3 req rises", {32'h0, reg_req}, 33'h1);
        polls = 0;
        xfer(pw, r);
        while (r == NR && polls < TO + 4) begin
            polls++;
            xfer(pw, r);
        end
        chk(seen_sel == sel, "R3 selector", {1'b0, seen_sel}, {1'b0, sel});
        chk(polls == ((d < TO) ? d + 1 : TO), "R4/R8 not-ready count", 33'(polls), 33'((d < TO) ? d + 1 : TO));
        if (fail_path) begin
            chk(r == BE, err ? "R7 bus error" : "R8 timeout", {16'h0, r}, {16'h0, BE});
        end else begin
            chk(r == {1'b0, exp[31:16]}, "R5/R6 upper word", {16'h0, r}, {16'h0, 1'b0, exp[31:16]});
            xfer(pw, r);
            chk(r == {1'b0, exp[15:0]}, "R5/R6 lower word", {16'h0, r}, {16'h0, 1'b0, exp[15:0]});
        end
        chk(reg_req == 1'b0, "R10 req low after", {32'h0, reg_req}, 33'h0);
        chk(tx_word == NR, "R9 back to not-ready", {16'h0, tx_word}, {16'h0, NR});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [16:0] r;
        logic [31:0] data, impl;
        bit          chained;
        repeat (3) @(negedge clk);
        chk(tx_word == NR, "R1 reset response", {16'h0, tx_word}, {16'h0, NR});
        chk(reg_req == 1'b0, "R1 reset req", {32'h0, reg_req}, 33'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: non-command words in idle
        xfer(16'h1234, r);
        chk(r == NR, "R2 idle response", {16'h0, r}, {16'h0, NR});
        xfer(16'hABCD, r);
        xfer(16'h0001, r);
        repeat (2) @(negedge clk);
        chk(reg_req == 1'b0, "R2 no fetch", {32'h0, reg_req}, 33'h0);
        chk(tx_word == NR, "R2 still idle", {16'h0, tx_word}, {16'h0, NR});

        // R10: stray acknowledge in idle
        stray = 1;
        repeat (3) @(negedge clk);
        stray = 0;
        @(negedge clk);
        chk(tx_word == NR, "R10 stray ack ignored", {16'h0, tx_word}, {16'h0, NR});
        chk(reg_req == 1'b0, "R10 stray ack no req", {32'h0, reg_req}, 33'h0);

        // R11: all-ones data stays distinct from status words
        rd(32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);

        chained = 0;
        for (int p = 0; p < 3; p++) begin
            for (int d = 0; d <= TO; d++) begin
                data = 32'h9E37_79B9 * 32'(d + 1) + 32'(p) * 32'h1111_1111;
                impl = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0000_FFFF : 32'hF0F0_0FF0;
                rd(data ^ 32'h5A5A_0000, data, impl, d, (d % 5) == 2, chained,
                   (d % 2) == 1 && !(p == 2 && d == TO));
                chained = (d % 2) == 1 && !(p == 2 && d == TO);
            end
        end

        // R11 status shape after a timeout
        rd(32'hFFFF_FFFF, 32'h1, 32'h1, TO, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule